// File: doc/BRIEF.md
# Programmable I/O Chip-Select Decoder

This block watches host I/O bus cycles and drives one active-low chip select per channel. A channel's select goes low in the same cycle when three things hold: the cycle is valid, its direction is one the channel allows, and its 16-bit I/O address falls inside the channel's window. Software sets the window with a 16-bit base address and a thermometer-coded range mask. The mask turns the lowest address bits into don't-care positions, so the window covers 1 to 32 bytes.

Each channel has two registers: a base word and a control byte. Software loads them through an index-addressed write port with byte enables, so the base can be written one byte at a time. The same index also selects a combinational read-back of the stored value. The default build has two channels, each driving its own select pin. The channels decode independently, and when both windows contain the address, both selects go low.

Top module: `iocs_decoder`

## Requirements
- R1: After reset every base register reads 0000h, every control register reads 0000h, and every chip select stays high for any I/O cycle.
- R2: While control bit 7 (decode enable) of a channel is 0, that channel's chip select stays high for every cycle.
- R3: Control bit 6 allows a channel's select to assert on write cycles (`io_write`=1) that hit its window. While bit 6 is 0, write cycles never assert it, whatever bit 5 holds.
- R4: Control bit 5 allows a channel's select to assert on read cycles (`io_write`=0) that hit its window. While bit 5 is 0, read cycles never assert it, whatever bit 6 holds.
- R5: Control bits [4:0] set the window. The codes 00000, 00001, 00011, 00111, 01111 and 11111 give 1, 2, 4, 8, 16 and 32 bytes. An address hits when it equals the base on every bit not set in the code.
- R6: A range code that is not one of the six legal codes decodes as the 1-byte window (exact match with the base). Read-back still returns the code exactly as it was written.
- R7: While `io_valid` is 0, every chip select is high.
- R8: On a write to a base register, `reg_be[0]` loads bits [7:0] and `reg_be[1]` loads bits [15:8]. A lane whose enable is 0 keeps its old value. On a write to a control register, the byte is loaded only when `reg_be[0]` is 1. The upper read-back byte of a control register is always 00h.
- R9: When one cycle hits the windows of both channels, both chip selects go low in that cycle. No priority applies between them.
- R10: Register index 2·c selects channel c's base register and index 2·c+1 selects its control register, for both write and read-back. A register changes only on a cycle in which `reg_wr` is 1 and `reg_idx` selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index (write target and read-back select) |
| reg_be | input | 2 | Byte-lane enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read-back of the register selected by `reg_idx` |
| io_valid | input | 1 | An I/O bus cycle is present |
| io_write | input | 1 | 1 = write cycle, 0 = read cycle |
| io_addr | input | 16 | I/O address of the cycle |
| io_cs_n | output | 2 | Active-low chip selects, bit c for channel c |

## Verification
The decoder is first driven with directed addresses placed on both sides of each window edge, one byte inside and one byte outside, for all six legal sizes. These cases show whether the mask is applied to the right low-order bits. Reserved range codes are then paired with addresses one byte away from the base, which tells a 1-byte fallback apart from raw use of the mask bits. Read and write cycles are run under each enable combination to separate the two direction qualifiers, and overlapping windows show that both selects assert together. A seeded random mix of partial-byte writes and cycles aimed near the programmed bases then compares both selects and the read-back against a bench model.

// File: rtl/iocs_pkg.sv
package iocs_pkg;

    localparam int IO_ADDR_W = 16;
    localparam int RANGE_W   = 5;
    localparam int CTRL_W    = 8;
    localparam int LANES     = IO_ADDR_W / 8;

    typedef logic [IO_ADDR_W-1:0] io_addr_t;

    // Field order sets the bit positions software sees: [7] en, [6] wr, [5] rd, [4:0] range
    typedef struct packed {
        logic               en;
        logic               wr_en;
        logic               rd_en;
        logic [RANGE_W-1:0] range;
    } chan_ctrl_t;

    // A thermometer code (0...01...1) is kept as is; any other code falls back to a 1-byte window
    function automatic logic [RANGE_W-1:0] legal_mask(input logic [RANGE_W-1:0] code);
        logic [RANGE_W:0] ext;
        logic [RANGE_W:0] inc;
        ext = {1'b0, code};
        inc = ext + (RANGE_W + 1)'(1);
        return ((ext & inc) == '0) ? code : '0;
    endfunction

endpackage

// File: rtl/iocs_window_match.sv
module iocs_window_match
    import iocs_pkg::*;
(
    input  io_addr_t   base,
    input  chan_ctrl_t ctrl,
    input  logic       io_valid,
    input  logic       io_write,
    input  io_addr_t   io_addr,
    output logic       hit
);

    logic [RANGE_W-1:0] mask;
    io_addr_t           care;
    logic               in_window;
    logic               dir_ok;

    always_comb begin
        mask      = legal_mask(ctrl.range);
        care      = ~io_addr_t'(mask);
        in_window = ((io_addr & care) == (base & care));
        dir_ok    = io_write ? ctrl.wr_en : ctrl.rd_en;
        hit       = io_valid && ctrl.en && dir_ok && in_window;
    end

endmodule

// File: rtl/iocs_regfile.sv
module iocs_regfile
    import iocs_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int IDX_W = $clog2(2 * NUM_CH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [IDX_W-1:0]      reg_idx,
    input  logic [LANES-1:0]      reg_be,
    input  io_addr_t              reg_wdata,
    output io_addr_t              reg_rdata,
    output io_addr_t [NUM_CH-1:0] base_o,
    output chan_ctrl_t [NUM_CH-1:0] ctrl_o
);

    typedef struct packed {
        io_addr_t   [NUM_CH-1:0] base;
        chan_ctrl_t [NUM_CH-1:0] ctrl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (reg_idx == IDX_W'(2 * c)) begin
                    for (int b = 0; b < LANES; b++) begin
                        if (reg_be[b]) begin
                            st_d.base[c][8*b +: 8] = reg_wdata[8*b +: 8];
                        end
                    end
                end
                if (reg_idx == IDX_W'(2 * c + 1) && reg_be[0]) begin
                    st_d.ctrl[c] = chan_ctrl_t'(reg_wdata[CTRL_W-1:0]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_idx == IDX_W'(2 * c)) begin
                reg_rdata = st_q.base[c];
            end
            if (reg_idx == IDX_W'(2 * c + 1)) begin
                reg_rdata = {{(IO_ADDR_W - CTRL_W){1'b0}}, st_q.ctrl[c]};
            end
        end
    end

    assign base_o = st_q.base;
    assign ctrl_o = st_q.ctrl;

endmodule

// File: rtl/iocs_decoder.sv
module iocs_decoder
    import iocs_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int IDX_W = $clog2(2 * NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [LANES-1:0]     reg_be,
    input  logic [IO_ADDR_W-1:0] reg_wdata,
    output logic [IO_ADDR_W-1:0] reg_rdata,
    input  logic                 io_valid,
    input  logic                 io_write,
    input  logic [IO_ADDR_W-1:0] io_addr,
    output logic [NUM_CH-1:0]    io_cs_n
);

    io_addr_t   [NUM_CH-1:0] base_vec;
    chan_ctrl_t [NUM_CH-1:0] ctrl_vec;
    logic       [NUM_CH-1:0] hit_vec;

    iocs_regfile #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .base_o    (base_vec),
        .ctrl_o    (ctrl_vec)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        iocs_window_match u_match (
            .base     (base_vec[c]),
            .ctrl     (ctrl_vec[c]),
            .io_valid (io_valid),
            .io_write (io_write),
            .io_addr  (io_addr),
            .hit      (hit_vec[c])
        );
    end

    assign io_cs_n = ~hit_vec;

endmodule

// File: rtl/iocs_decoder_chk.sv
module iocs_decoder_chk
    import iocs_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_wr,
    input logic                    io_valid,
    input logic                    io_write,
    input logic [NUM_CH-1:0]       io_cs_n,
    input io_addr_t   [NUM_CH-1:0] base,
    input chan_ctrl_t [NUM_CH-1:0] ctrl
);

    a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid |-> (io_cs_n == '1));

    a_r10_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(base) && $stable(ctrl)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        a_r2_disabled_high: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl[c].en |-> io_cs_n[c]);

        a_r3_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
            (io_valid && io_write && !ctrl[c].wr_en) |-> io_cs_n[c]);

        a_r4_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
            (io_valid && !io_write && !ctrl[c].rd_en) |-> io_cs_n[c]);
    end

endmodule

bind iocs_decoder iocs_decoder_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .io_valid (io_valid),
    .io_write (io_write),
    .io_cs_n  (io_cs_n),
    .base     (base_vec),
    .ctrl     (ctrl_vec)
);

// File: tb/tb_iocs_decoder.sv
module tb_iocs_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [1:0]  reg_be = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_cs_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] m_base [2];
    logic [7:0]  m_ctrl [2];

    always #2.5 clk = ~clk;

    iocs_decoder dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
        .io_cs_n(io_cs_n)
    );

    function automatic logic [4:0] eff_mask(input logic [4:0] code);
        case (code)
            5'b00000, 5'b00001, 5'b00011, 5'b00111, 5'b01111, 5'b11111: return code;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic logic [1:0] exp_cs(input logic v, input logic w, input logic [15:0] a);
        logic [1:0] r;
        r = 2'b11;
        for (int c = 0; c < 2; c++) begin
            logic [15:0] care;
            logic        dir;
            care = ~{11'b0, eff_mask(m_ctrl[c][4:0])};
            dir  = w ? m_ctrl[c][6] : m_ctrl[c][5];
            if (v && m_ctrl[c][7] && dir && ((a & care) == (m_base[c] & care))) r[c] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_rd(input int idx);
        if (idx % 2 == 0) return m_base[idx / 2];
        return {8'h00, m_ctrl[idx / 2]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx[1:0]; reg_wdata = d; reg_be = be;
        if (idx % 2 == 0) begin
            if (be[0]) m_base[idx / 2][7:0]  = d[7:0];
            if (be[1]) m_base[idx / 2][15:8] = d[15:8];
        end else if (be[0]) begin
            m_ctrl[idx / 2] = d[7:0];
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input int idx, input string tag);
        @(negedge clk);
        reg_idx = idx[1:0];
        #1 chk(tag, reg_rdata, exp_rd(idx));
    endtask

    task automatic cyc(input logic v, input logic w, input logic [15:0] a, input string tag);
        @(negedge clk);
        io_valid = v; io_write = w; io_addr = a;
        #1 chk(tag, {14'b0, io_cs_n}, {14'b0, exp_cs(v, w, a)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [4:0] codes [8];
        codes = '{5'b00000, 5'b00001, 5'b00011, 5'b00111, 5'b01111, 5'b11111, 5'b00101, 5'b10000};
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin m_base[c] = '0; m_ctrl[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and quiet selects
        for (int i = 0; i < 4; i++) rd_chk(i, "R1 reset readback");
        cyc(1'b1, 1'b0, 16'h0000, "R1 reset read cycle");
        cyc(1'b1, 1'b1, 16'h0000, "R1 reset write cycle");

        // R8: byte-lane loads of channel 1 base
        wr(2, 16'hABCD, 2'b01);
        rd_chk(2, "R8 low lane only");
        wr(2, 16'h12EF, 2'b10);
        rd_chk(2, "R8 high lane only");
        wr(3, 16'hFF00, 2'b10);
        rd_chk(3, "R8 ctrl ignores high-lane-only write");
        wr(3, 16'h5A00, 2'b11);
        rd_chk(3, "R8 ctrl upper byte reads zero");

        // R5: every legal size, edges just inside and just outside
        for (int s = 0; s < 6; s++) begin
            int sz;
            sz = 1 << s;
            wr(0, 16'h0340, 2'b11);
            wr(1, {8'h00, 3'b111, codes[s]}, 2'b01);
            cyc(1'b1, 1'b0, 16'h0340, "R5 first byte");
            cyc(1'b1, 1'b0, 16'(16'h0340 + sz - 1), "R5 last byte");
            cyc(1'b1, 1'b1, 16'(16'h0340 + sz), "R5 past window");
            cyc(1'b1, 1'b1, 16'h033F, "R5 below window");
        end

        // R6: reserved codes behave as 1 byte, readback raw
        wr(1, 16'h00E5, 2'b01);
        rd_chk(1, "R6 raw reserved code");
        cyc(1'b1, 1'b0, 16'h0340, "R6 exact hit");
        cyc(1'b1, 1'b0, 16'h0341, "R6 next byte misses");
        wr(1, 16'h00F0, 2'b01);
        cyc(1'b1, 1'b1, 16'h0350, "R6 code 10000 next region misses");

        // R2: disabled channel
        wr(1, 16'h007F, 2'b01);
        cyc(1'b1, 1'b0, 16'h0340, "R2 disabled read");
        cyc(1'b1, 1'b1, 16'h0340, "R2 disabled write");

        // R3 / R4: direction qualifiers
        wr(1, 16'h00C3, 2'b01);
        cyc(1'b1, 1'b1, 16'h0342, "R3 write allowed");
        cyc(1'b1, 1'b0, 16'h0342, "R4 read blocked");
        wr(1, 16'h00A3, 2'b01);
        cyc(1'b1, 1'b1, 16'h0342, "R3 write blocked");
        cyc(1'b1, 1'b0, 16'h0342, "R4 read allowed");

        // R7: no valid cycle
        wr(1, 16'h00FF, 2'b01);
        cyc(1'b0, 1'b0, 16'h0340, "R7 idle read");
        cyc(1'b0, 1'b1, 16'h0345, "R7 idle write");

        // R9: overlapping windows
        wr(2, 16'h0348, 2'b11);
        wr(3, 16'h00E7, 2'b01);
        cyc(1'b1, 1'b0, 16'h034A, "R9 both assert");
        cyc(1'b1, 1'b1, 16'h0342, "R9 only channel 0");

        // R10: index map readback
        for (int i = 0; i < 4; i++) rd_chk(i, "R10 index map");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom % 8);
            if (op < 2) begin
                int idx;
                logic [15:0] d;
                idx = int'($urandom % 4);
                if (idx % 2 == 0) d = 16'($urandom);
                else d = {8'($urandom), 3'($urandom), codes[$urandom % 8]};
                wr(idx, d, 2'($urandom));
                rd_chk(idx, "R10 random readback");
            end else begin
                logic [15:0] a;
                int c;
                c = int'($urandom % 2);
                a = (op == 7) ? 16'($urandom) : 16'(m_base[c] + ($urandom % 40) - 4);
                cyc(1'($urandom % 5 != 0), 1'($urandom), a, "R5 random cycle");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule